// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block keeps the per-pin control state of a 40-pin general purpose I/O expander, arranged as five banks of eight pins. Every bank owns five byte-wide registers: a sampled input view, an output latch, a polarity-inversion mask applied to input reads, a direction register and an interrupt mask. A host-side interface block, such as a serial bus slave, issues single-cycle read and write strobes with a six-bit register address. The register file drives the output value and output enable of every pin and samples the pin levels every clock.

Reads are handled by a small access state machine. In state `S_IDLE` no read data is pending. A read strobe moves it to `S_RESP` (transition *issue*), where `rd_valid` is high for one cycle with the registered data. A further strobe in `S_RESP` keeps it there (transition *chain*, for back-to-back reads). With no strobe it returns to `S_IDLE` (transition *drain*) or stays there (transition *rest*). A global active-low output enable removes the drive from every pin without altering any register.

Top module: `gpx_port_regfile`

## Requirements
- R1: After synchronous reset every output latch and polarity register reads 0x00, every direction and interrupt mask register reads 0xFF, and every `pin_oe` bit is 0.
- R2: The address field `addr[5:3]` selects the register kind (0 input, 1 output, 2 polarity, 3 direction, 4 mask) and `addr[2:0]` selects the bank (0 to 4). A read strobe in cycle n gives `rd_valid` high with `rdata` in cycle n+1, and only then.
- R3: An input register read returns the pin levels captured one clock earlier, XORed bit by bit with the bank's polarity register. This holds whatever the pin's direction.
- R4: An output register read returns the latch contents, not the pin level, and the latch drives `pin_out` from the clock edge that completes the write.
- R5: A pin is driven (`pin_oe` = 1) only when its direction bit is 0 and `oe_n` is low. A direction bit of 1 makes the pin an input.
- R6: While `oe_n` is high every `pin_oe` bit is 0. The output latches keep their values, and the previous drive returns when `oe_n` falls.
- R7: Writes to input register addresses (kind 0) change no register.
- R8: Addresses with kind 5 to 7 or bank 5 to 7 read as 0x00, and writes to them change no register and no pin.
- R9: Interrupt mask registers hold and read back written values.
- R10: A write takes effect at the clock edge of its strobe. A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register address: kind in [5:3], bank in [2:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| pin_in | input | 40 | Pin levels, bank b at bits [8b+7:8b] |
| pin_out | output | 40 | Output latch values per pin |
| pin_oe | output | 40 | Per-pin drive enable |
| oe_n | input | 1 | Global output enable, active low |

## Verification
A wrong direction or output latch bit appears on `pin_oe` or `pin_out` at the next falling clock after the faulty write, even before any read. A corrupted polarity bit, input sample or read select appears only in `rdata`, one cycle after the read strobe that addresses it. Because of this, every register kind is read back after being written and after reset. A lost or extra `rd_valid` shows up as an empty or leftover slot in the scoreboard queue at the cycle it happens.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // register kind carried in the upper address field
    typedef enum logic [2:0] {
        K_IN  = 3'd0,
        K_OUT = 3'd1,
        K_POL = 3'd2,
        K_CFG = 3'd3,
        K_MSK = 3'd4
    } reg_kind_e;

    // read access state machine
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [2:0]        kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pin_in,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] pol_q,
    output logic [BANK_W-1:0] cfg_q,
    output logic [BANK_W-1:0] msk_q,
    output logic [BANK_W-1:0] in_view
);

    logic [BANK_W-1:0] in_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            pol_q  <= '0;
            cfg_q  <= '1;
            msk_q  <= '1;
            in_smp <= '0;
        end else begin
            in_smp <= pin_in;
            if (wr_sel) begin
                case (kind)
                    K_OUT:   out_q <= wdata;
                    K_POL:   pol_q <= wdata;
                    K_CFG:   cfg_q <= wdata;
                    K_MSK:   msk_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign in_view = in_smp ^ pol_q;

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '1 && msk_q == '1 && out_q == '0 && pol_q == '0)); // R1

    AST_INPUT_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && kind == K_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q) && $stable(msk_q))); // R7

endmodule

// File: rtl/gpx_access_fsm.sv
module gpx_access_fsm
    import gpx_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int BSEL_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [NUM_BANKS*BANK_W-1:0] in_all,
    input  logic [NUM_BANKS*BANK_W-1:0] out_all,
    input  logic [NUM_BANKS*BANK_W-1:0] pol_all,
    input  logic [NUM_BANKS*BANK_W-1:0] cfg_all,
    input  logic [NUM_BANKS*BANK_W-1:0] msk_all,
    output logic [BANK_W-1:0]           rdata,
    output logic                        rd_valid
);

    localparam int KIND_W = ADDR_W - BSEL_W;

    acc_state_e        state_q, state_d;
    logic [BSEL_W-1:0] bank;
    logic [KIND_W-1:0] kind;
    logic [BANK_W-1:0] word;

    assign bank = rd_addr[BSEL_W-1:0];
    assign kind = rd_addr[ADDR_W-1:BSEL_W];

    // read select: unmapped kinds and banks give zero
    always_comb begin
        word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BSEL_W'(b)) begin
                case (kind)
                    KIND_W'(K_IN):  word = in_all [b*BANK_W +: BANK_W];
                    KIND_W'(K_OUT): word = out_all[b*BANK_W +: BANK_W];
                    KIND_W'(K_POL): word = pol_all[b*BANK_W +: BANK_W];
                    KIND_W'(K_CFG): word = cfg_all[b*BANK_W +: BANK_W];
                    KIND_W'(K_MSK): word = msk_all[b*BANK_W +: BANK_W];
                    default:        word = '0;
                endcase
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = rd_en ? S_RESP : S_IDLE;  // issue / rest
            S_RESP: state_d = rd_en ? S_RESP : S_IDLE;  // chain / drain
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= word;
    end

    assign rd_valid = (state_q == S_RESP);

    AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R2

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (kind > KIND_W'(K_MSK) || int'(bank) >= NUM_BANKS)) |=> (rdata == '0)); // R8

endmodule

// File: rtl/gpx_port_regfile.sv
module gpx_port_regfile
    import gpx_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BANK_W-1:0]           wdata,
    output logic [BANK_W-1:0]           rdata,
    output logic                        rd_valid,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    input  logic                        oe_n
);

    localparam int PINS   = NUM_BANKS * BANK_W;
    localparam int BSEL_W = 3;
    localparam int KIND_W = ADDR_W - BSEL_W;

    logic [PINS-1:0]   in_all, out_all, pol_all, cfg_all, msk_all;
    logic [KIND_W-1:0] kind;
    logic [BSEL_W-1:0] bank;

    assign kind = addr[ADDR_W-1:BSEL_W];
    assign bank = addr[BSEL_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_sel;
        assign wr_sel = wr_en && (bank == BSEL_W'(b));

        gpx_bank #(.BANK_W(BANK_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_sel  (wr_sel),
            .kind    (3'(kind)),
            .wdata   (wdata),
            .pin_in  (pin_in [b*BANK_W +: BANK_W]),
            .out_q   (out_all[b*BANK_W +: BANK_W]),
            .pol_q   (pol_all[b*BANK_W +: BANK_W]),
            .cfg_q   (cfg_all[b*BANK_W +: BANK_W]),
            .msk_q   (msk_all[b*BANK_W +: BANK_W]),
            .in_view (in_all [b*BANK_W +: BANK_W])
        );

        AST_OUT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            (wr_sel && kind == KIND_W'(K_OUT)) |=> (pin_out[b*BANK_W +: BANK_W] == $past(wdata))); // R4
    end

    gpx_access_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W),
        .BSEL_W    (BSEL_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (addr),
        .in_all   (in_all),
        .out_all  (out_all),
        .pol_all  (pol_all),
        .cfg_all  (cfg_all),
        .msk_all  (msk_all),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    assign pin_out = out_all;
    assign pin_oe  = ~cfg_all & {PINS{~oe_n}};

    AST_OE_HIGH_TRISTATES: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (pin_oe == '0)); // R6

    AST_IDLE_KEEPS_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_all)); // R10

endmodule

// File: tb/gpx_port_regfile_test.sv
module gpx_port_regfile_test;

    localparam int NB = 5;
    localparam int BW = 8;
    localparam int PW = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          rd_valid;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out;
    logic [PW-1:0] pin_oe;
    logic          oe_n = 1'b0;

    int n_cmp  = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2 clk = ~clk;

    gpx_port_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .oe_n(oe_n)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per valid read
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected rd_valid", 64'(rdata), 64'hDEAD);
            end else begin
                check(req_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    // one bus cycle; leaves strobes low afterwards
    task automatic op(logic wr, logic rd, logic [5:0] a, logic [7:0] d,
                      logic [7:0] exp, string req);
        wr_en = wr; rd_en = rd; addr = a; wdata = d;
        if (rd) begin
            exp_q.push_back(exp);
            req_q.push_back(req);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        op(1'b1, 1'b0, a, d, 8'h00, "");
    endtask

    task automatic rd(logic [5:0] a, logic [7:0] exp, string req);
        op(1'b0, 1'b1, a, 8'h00, exp, req);
    endtask

    task automatic finish_run();
        check("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe after reset", 64'(pin_oe), 64'd0);
        check("R1 pin_out after reset", 64'(pin_out), 64'd0);
        for (int b = 0; b < NB; b++) rd(6'(8'h18 + b), 8'hFF, "R1 direction reset");
        rd(6'h22, 8'hFF, "R1 mask reset");
        rd(6'h0B, 8'h00, "R1 output reset");
        rd(6'h11, 8'h00, "R1 polarity reset");

        // R3 input sampling and inversion
        pin_in = 40'hA5_3C_F0_0F_81;
        repeat (2) @(negedge clk);
        rd(6'h00, 8'h81, "R3 input bank0");
        rd(6'h04, 8'hA5, "R3 input bank4");
        wr(6'h10, 8'hFF);
        wr(6'h14, 8'h0F);
        rd(6'h00, 8'h7E, "R3 inverted bank0");
        rd(6'h04, 8'hAA, "R3 inverted bank4");

        // R4 output latch versus pin level
        wr(6'h09, 8'h5A);
        check("R4 pin_out bank1", 64'(pin_out[15:8]), 64'h5A);
        rd(6'h09, 8'h5A, "R4 output readback");

        // R5 direction: 0 drives
        wr(6'h19, 8'h0F);
        check("R5 pin_oe bank1", 64'(pin_oe[15:8]), 64'hF0);
        check("R5 pin_oe others", 64'({pin_oe[39:16], pin_oe[7:0]}), 64'd0);
        rd(6'h01, 8'h0F, "R3 input read on output pins");

        // R6 global output enable
        oe_n = 1'b1;
        @(negedge clk);
        check("R6 pin_oe with oe_n high", 64'(pin_oe), 64'd0);
        rd(6'h09, 8'h5A, "R6 latch kept");
        oe_n = 1'b0;
        @(negedge clk);
        check("R6 drive restored", 64'(pin_oe[15:8]), 64'hF0);

        // R7 input writes ignored
        wr(6'h00, 8'h00);
        wr(6'h01, 8'hFF);
        rd(6'h00, 8'h7E, "R7 input bank0 unchanged");
        rd(6'h10, 8'hFF, "R7 polarity bank0 unchanged");
        rd(6'h19, 8'h0F, "R7 direction bank1 unchanged");
        check("R7 pins unchanged", 64'(pin_oe[15:8]), 64'hF0);

        // R8 unmapped addresses
        rd(6'h05, 8'h00, "R8 bank5 read");
        rd(6'h28, 8'h00, "R8 kind5 read");
        rd(6'h3F, 8'h00, "R8 kind7 read");
        wr(6'h0D, 8'hFF);
        wr(6'h1F, 8'h00);
        wr(6'h2B, 8'h00);
        check("R8 pin_out unchanged", 64'(pin_out), 64'(40'h00_00_00_5A_00));
        check("R8 pin_oe unchanged", 64'(pin_oe), 64'(40'h00_00_00_F0_00));

        // R9 mask storage
        wr(6'h23, 8'h12);
        rd(6'h23, 8'h12, "R9 mask readback");
        rd(6'h24, 8'hFF, "R9 neighbour mask untouched");

        // R10 same-cycle read and write, then back-to-back reads
        op(1'b1, 1'b1, 6'h0A, 8'h33, 8'h00, "R10 read sees old value");
        rd(6'h0A, 8'h33, "R10 read sees new value");
        rd(6'h09, 8'h5A, "R10 back-to-back read 2");
        check("R10 pin_out bank2", 64'(pin_out[23:16]), 64'h33);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule